// File: doc/BRIEF.md
# SPI EEPROM Page-Write Controller

This block is the write path of a serial EEPROM slave that uses SPI mode 0. The chip select, serial clock and serial data input are brought into the system clock domain through synchronisers and sampled there. A frame that opens with the write opcode carries a 16-bit address and then one or more data bytes. The data bytes are collected into a 64-byte page buffer. Each byte slot in the buffer has its own valid flag.

When chip select rises, the controller decides whether to commit the page. It commits only if every one of these holds:
- the frame ended exactly on a byte boundary;
- the write-enable latch is set;
- no earlier write cycle is still running;
- the addressed page lies outside the region picked by the two block-protect bits.

An accepted page is written into the internal byte array in a single clock. The write-in-progress flag then stays high for a fixed number of system clocks. A refused frame leaves the array and the timer untouched.

The other instructions are reduced to sideband inputs:
- a pulse that sets the write-enable latch;
- a load strobe for the block-protect bits;
- a combinational read port into the array.

Top module: `spi_page_writer`

## Requirements
- R1: After reset, wip and wel are 0, bp is 00, and every array byte reads 8'hFF.
- R2: Bits are sampled MSB first on each rising edge of sck while cs_n is low, and the bit counter clears while cs_n is high. A frame of opcode 8'h02, address high byte, address low byte and one data byte, ended on a byte boundary with wel set and wip clear, stores that byte at the addressed location.
- R3: Address bits at or above the array address width are ignored. This includes b15 and b14, so 16'hC09A writes location 9'h09A with the default width of 9.
- R4: After each data byte only the low 6 address bits advance. Bytes past offset 63 wrap to offset 0 of the same page, and the latest byte sent to an offset is the one stored.
- R5: Bytes of the page that were not sent keep their previous contents.
- R6: If cs_n rises while a byte is only partly shifted in, the frame is discarded. The array is unchanged, wip stays 0 and wel keeps its value.
- R7: A write frame is refused when wel is 0.
- R8: A write frame that ends while wip is 1 is refused, and the running cycle is unaffected.
- R9: The bp encoding is:
  - 00 protects nothing;
  - 01 protects the top quarter of the array (the two top address bits are 11);
  - 10 protects the top half (the top address bit is 1);
  - 11 protects the whole array.

  A write to a protected page is refused and clears wel.
- R10: An accepted write holds wip at 1 for exactly WC_CYCLES system clocks, then wip returns to 0 and wel is cleared.
- R11: A frame whose opcode is not 8'h02 changes neither the array, wip nor wel.
- R12: A wren_set pulse sets wel in the next clock. A bp_load strobe copies bp_in into bp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data input |
| wren_set | input | 1 | Pulse that sets the write-enable latch |
| bp_load | input | 1 | Strobe that loads bp_in into the protect bits |
| bp_in | input | 2 | New block-protect value |
| rd_addr | input | AW | Byte address of the read sideband |
| rd_data | output | 8 | Array byte at rd_addr |
| wip | output | 1 | Write cycle in progress |
| wel | output | 1 | Write-enable latch |
| bp | output | 2 | Current block-protect bits |

## Verification
The hardest case to reach from the ports is a refusal for a busy cycle. The second frame has to finish its last byte while the first write's timer is still running. To get there, the default cycle length is made longer than a complete byte-write frame. The bench re-arms the latch during the busy window and sends a second frame straight away. It then checks that the second frame's target is untouched and that the first write's byte landed. A partial-byte termination is produced by clocking three extra bits after the data byte before chip select is raised.

// File: rtl/spw_pkg.sv
package spw_pkg;

    localparam int PAGE_BYTES = 64;
    localparam int PAGE_OFS_W = 6;
    localparam logic [7:0] OPC_WRITE = 8'h02;

    typedef enum logic [2:0] {
        FS_OPC,
        FS_AHI,
        FS_ALO,
        FS_DATA,
        FS_SKIP
    } frame_state_t;

    typedef struct packed {
        logic       byte_vld;
        logic [7:0] byte_val;
        logic       cs_rise;
        logic       on_boundary;
        logic       cs_high;
    } rx_evt_t;

    typedef logic [PAGE_BYTES-1:0][7:0] page_data_t;
    typedef logic [PAGE_BYTES-1:0]      page_mask_t;

    function automatic logic page_locked(input logic [1:0] bp_v, input logic [1:0] top2);
        logic r;
        unique case (bp_v)
            2'b00: r = 1'b0;
            2'b01: r = (top2 == 2'b11);
            2'b10: r = top2[1];
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/spw_serial_rx.sv
module spw_serial_rx
    import spw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sck,
    input  logic    mosi,
    output rx_evt_t evt
);

    logic [SYNC_STAGES-1:0] cs_sy, sck_sy, d_sy;
    logic cs_lvl, sck_lvl, d_lvl;
    logic cs_prev, sck_prev;
    logic sck_rise;
    logic [2:0] bit_cnt;
    logic [6:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_sy    <= '1;
            sck_sy   <= '0;
            d_sy     <= '0;
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_sy    <= {cs_sy[SYNC_STAGES-2:0], cs_n};
            sck_sy   <= {sck_sy[SYNC_STAGES-2:0], sck};
            d_sy     <= {d_sy[SYNC_STAGES-2:0], mosi};
            cs_prev  <= cs_lvl;
            sck_prev <= sck_lvl;
        end
    end

    assign cs_lvl   = cs_sy[SYNC_STAGES-1];
    assign sck_lvl  = sck_sy[SYNC_STAGES-1];
    assign d_lvl    = d_sy[SYNC_STAGES-1];
    assign sck_rise = sck_lvl & ~sck_prev;

    always_ff @(posedge clk) begin
        if (rst || cs_lvl) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (sck_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            shreg   <= {shreg[5:0], d_lvl};
        end
    end

    always_comb begin
        evt.byte_vld    = sck_rise & ~cs_lvl & (bit_cnt == 3'd7);
        evt.byte_val    = {shreg, d_lvl};
        evt.cs_rise     = cs_lvl & ~cs_prev;
        evt.on_boundary = (bit_cnt == 3'd0);
        evt.cs_high     = cs_lvl;
    end

endmodule

// File: rtl/spw_frame_ctrl.sv
module spw_frame_ctrl
    import spw_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  rx_evt_t          evt,
    input  logic             wren_set,
    input  logic             bp_load,
    input  logic [1:0]       bp_in,
    input  logic             busy,
    input  logic             cyc_done,
    output logic             wel,
    output logic [1:0]       bp,
    output logic             commit,
    output logic [AW-7:0]    page_idx,
    output page_data_t       pdata,
    output page_mask_t       pmask
);

    frame_state_t          st;
    logic [AW-1:0]         addr_q;
    logic [PAGE_OFS_W-1:0] ptr;
    logic                  have_data;
    logic                  wel_q;
    logic [1:0]            bp_q;
    logic                  frame_ok, locked, prot_rej;

    assign locked   = page_locked(bp_q, addr_q[AW-1 -: 2]);
    assign frame_ok = evt.cs_rise && (st == FS_DATA) && have_data && evt.on_boundary;
    assign commit   = frame_ok && wel_q && !busy && !locked;
    assign prot_rej = frame_ok && !busy && locked;
    assign page_idx = addr_q[AW-1:PAGE_OFS_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= FS_OPC;
            addr_q    <= '0;
            ptr       <= '0;
            have_data <= 1'b0;
            pmask     <= '0;
            pdata     <= '0;
        end else if (evt.cs_high) begin
            st        <= FS_OPC;
            have_data <= 1'b0;
            pmask     <= '0;
        end else if (evt.byte_vld) begin
            unique case (st)
                FS_OPC:  st <= (evt.byte_val == OPC_WRITE) ? FS_AHI : FS_SKIP;
                FS_AHI: begin
                    addr_q[AW-1:8] <= evt.byte_val[AW-9:0];
                    st             <= FS_ALO;
                end
                FS_ALO: begin
                    addr_q[7:0] <= evt.byte_val;
                    ptr         <= evt.byte_val[PAGE_OFS_W-1:0];
                    st          <= FS_DATA;
                end
                FS_DATA: begin
                    pdata[ptr] <= evt.byte_val;
                    pmask[ptr] <= 1'b1;
                    ptr        <= ptr + 1'b1;
                    have_data  <= 1'b1;
                end
                default: st <= FS_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q <= 1'b0;
            bp_q  <= 2'b00;
        end else begin
            if (cyc_done || prot_rej)
                wel_q <= 1'b0;
            else if (wren_set)
                wel_q <= 1'b1;
            if (bp_load)
                bp_q <= bp_in;
        end
    end

    assign wel = wel_q;
    assign bp  = bp_q;

    // R10
    wel_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wel_q) |-> $past(cyc_done || prot_rej));

    // R12
    wel_set_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wel_q) |-> $past(wren_set));

endmodule

// File: rtl/spw_cycle_timer.sv
module spw_cycle_timer #(
    parameter int WC_CYCLES = 600
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CNT_W = (WC_CYCLES > 1) ? $clog2(WC_CYCLES) : 1;

    logic [CNT_W-1:0] cnt;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt    <= CNT_W'(WC_CYCLES - 1);
        end else if (busy_q) begin
            if (cnt == '0)
                busy_q <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt == '0);

    // R8
    start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

    // R10
    busy_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(start));

endmodule

// File: rtl/spw_byte_array.sv
module spw_byte_array
    import spw_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-7:0] page_idx,
    input  page_data_t    pdata,
    input  page_mask_t    pmask,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= 8'hFF;
        end else if (we) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (pmask[i])
                    mem[{page_idx, PAGE_OFS_W'(i)}] <= pdata[i];
        end
    end

    assign rd_data = mem[rd_addr];

    // R5
    array_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> (!$stable(rd_addr) || $stable(rd_data)));

endmodule

// File: rtl/spi_page_writer.sv
module spi_page_writer
    import spw_pkg::*;
#(
    parameter int AW          = 9,
    parameter int WC_CYCLES   = 600,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          mosi,
    input  logic          wren_set,
    input  logic          bp_load,
    input  logic [1:0]    bp_in,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          wip,
    output logic          wel,
    output logic [1:0]    bp
);

    rx_evt_t       evt;
    logic          commit, busy, done;
    logic [AW-7:0] page_idx;
    page_data_t    pdata;
    page_mask_t    pmask;

    spw_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .evt(evt)
    );

    spw_frame_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .evt(evt), .wren_set(wren_set),
        .bp_load(bp_load), .bp_in(bp_in), .busy(busy), .cyc_done(done),
        .wel(wel), .bp(bp), .commit(commit), .page_idx(page_idx),
        .pdata(pdata), .pmask(pmask)
    );

    spw_cycle_timer #(.WC_CYCLES(WC_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(commit), .busy(busy), .done(done)
    );

    spw_byte_array #(.AW(AW)) u_mem (
        .clk(clk), .rst(rst), .we(commit), .page_idx(page_idx),
        .pdata(pdata), .pmask(pmask), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign wip = busy;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!wip && !wel && bp == 2'b00));

endmodule

// File: tb/tb_spi_page_writer.sv
`timescale 1ns/1ps
module tb_spi_page_writer;

    localparam int AW = 9;
    localparam int WC = 600;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic wren_set = 1'b0, bp_load = 1'b0;
    logic [1:0] bp_in = 2'b00;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic wip, wel;
    logic [1:0] bp;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] dbuf [0:71];

    spi_page_writer #(.AW(AW), .WC_CYCLES(WC)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .wren_set(wren_set), .bp_load(bp_load), .bp_in(bp_in),
        .rd_addr(rd_addr), .rd_data(rd_data), .wip(wip), .wel(wel), .bp(bp)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic negs(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_chk(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
        @(negedge clk);
        rd_addr = a;
        #2;
        chk(tag, rd_data, exp);
    endtask

    task automatic spi_bit(input logic b);
        @(negedge clk);
        mosi = b;
        negs(4);
        sck = 1'b1;
        negs(4);
        sck = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) spi_bit(b[i]);
    endtask

    task automatic frame(input logic [7:0] opc, input logic [15:0] a, input int n, input int extra);
        negs(4);
        cs_n = 1'b0;
        negs(4);
        spi_byte(opc);
        spi_byte(a[15:8]);
        spi_byte(a[7:0]);
        for (int i = 0; i < n; i++) spi_byte(dbuf[i]);
        for (int i = 0; i < extra; i++) spi_bit(1'b1);
        negs(4);
        cs_n = 1'b1;
        negs(1);
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        for (int t = 0; t < WC + 100; t++) begin
            @(negedge clk);
            if (wip) cnt++;
            else if (cnt > 0) break;
        end
    endtask

    task automatic set_wel();
        @(negedge clk);
        wren_set = 1'b1;
        @(negedge clk);
        wren_set = 1'b0;
    endtask

    task automatic load_bp(input logic [1:0] v);
        @(negedge clk);
        bp_in = v;
        bp_load = 1'b1;
        @(negedge clk);
        bp_load = 1'b0;
        chk("R12 bp load", bp, v);
    endtask

    task automatic t_reset();
        chk("R1 wip", wip, 0);
        chk("R1 wel", wel, 0);
        chk("R1 bp", bp, 0);
        read_chk("R1 array erased", 9'h000, 8'hFF);
    endtask

    task automatic t_byte_write();
        int c;
        set_wel();
        chk("R12 wel set", wel, 1);
        dbuf[0] = 8'hA5;
        frame(8'h02, 16'h0085, 1, 0);
        wait_idle(c);
        chk("R10 wip length", c, WC);
        chk("R10 wel cleared", wel, 0);
        read_chk("R2 byte stored", 9'h085, 8'hA5);
        read_chk("R5 below kept", 9'h084, 8'hFF);
        read_chk("R5 above kept", 9'h086, 8'hFF);
    endtask

    task automatic t_no_wel();
        int c;
        dbuf[0] = 8'h66;
        frame(8'h02, 16'h0020, 1, 0);
        wait_idle(c);
        chk("R7 no cycle", c, 0);
        read_chk("R7 array unchanged", 9'h020, 8'hFF);
    endtask

    task automatic t_alias();
        int c;
        set_wel();
        dbuf[0] = 8'h5A;
        frame(8'h02, 16'hC09A, 1, 0);
        wait_idle(c);
        read_chk("R3 high bits ignored", 9'h09A, 8'h5A);
    endtask

    task automatic t_wrap();
        int c;
        set_wel();
        dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33; dbuf[3] = 8'h44;
        frame(8'h02, 16'h00FE, 4, 0);
        wait_idle(c);
        chk("R10 multi-byte one cycle", c, WC);
        read_chk("R4 offset 62", 9'h0FE, 8'h11);
        read_chk("R4 offset 63", 9'h0FF, 8'h22);
        read_chk("R4 wrapped offset 0", 9'h0C0, 8'h33);
        read_chk("R4 wrapped offset 1", 9'h0C1, 8'h44);
        read_chk("R5 unsent offset 2", 9'h0C2, 8'hFF);
    endtask

    task automatic t_full_wrap();
        int c;
        set_wel();
        for (int i = 0; i < 65; i++) dbuf[i] = 8'(i + 1);
        frame(8'h02, 16'h0100, 65, 0);
        wait_idle(c);
        read_chk("R4 overwrite offset 0", 9'h100, 8'h41);
        read_chk("R4 offset 1", 9'h101, 8'h02);
        read_chk("R4 offset 63", 9'h13F, 8'h40);
    endtask

    task automatic t_off_boundary();
        int c;
        set_wel();
        dbuf[0] = 8'h77;
        frame(8'h02, 16'h0030, 1, 3);
        wait_idle(c);
        chk("R6 no cycle", c, 0);
        chk("R6 wel kept", wel, 1);
        read_chk("R6 array unchanged", 9'h030, 8'hFF);
    endtask

    task automatic t_opcode();
        int c;
        dbuf[0] = 8'h77;
        frame(8'h03, 16'h0010, 1, 0);
        wait_idle(c);
        chk("R11 no cycle", c, 0);
        chk("R11 wel kept", wel, 1);
        read_chk("R11 array unchanged", 9'h010, 8'hFF);
    endtask

    task automatic t_protect();
        int c;
        load_bp(2'b01);
        dbuf[0] = 8'h12;
        frame(8'h02, 16'h0190, 1, 0);
        wait_idle(c);
        chk("R9 bp01 top quarter refused", c, 0);
        chk("R9 reject clears wel", wel, 0);
        read_chk("R9 bp01 unchanged", 9'h190, 8'hFF);
        set_wel();
        dbuf[0] = 8'h34;
        frame(8'h02, 16'h017F, 1, 0);
        wait_idle(c);
        chk("R9 bp01 below quarter accepted", c, WC);
        read_chk("R9 bp01 stored", 9'h17F, 8'h34);
        load_bp(2'b10);
        set_wel();
        dbuf[0] = 8'h56;
        frame(8'h02, 16'h0100, 1, 0);
        wait_idle(c);
        chk("R9 bp10 wel cleared", wel, 0);
        read_chk("R9 bp10 upper half refused", 9'h100, 8'h41);
        load_bp(2'b11);
        set_wel();
        dbuf[0] = 8'h78;
        frame(8'h02, 16'h0000, 1, 0);
        wait_idle(c);
        read_chk("R9 bp11 whole array refused", 9'h000, 8'hFF);
        load_bp(2'b00);
        set_wel();
        dbuf[0] = 8'h9A;
        frame(8'h02, 16'h01C0, 1, 0);
        wait_idle(c);
        read_chk("R9 bp00 top page accepted", 9'h1C0, 8'h9A);
    endtask

    task automatic t_busy();
        int c;
        set_wel();
        dbuf[0] = 8'h01;
        frame(8'h02, 16'h0040, 1, 0);
        negs(3);
        chk("R8 first write running", wip, 1);
        set_wel();
        dbuf[0] = 8'h99;
        frame(8'h02, 16'h0050, 1, 0);
        chk("R8 still busy at second end", wip, 1);
        wait_idle(c);
        read_chk("R8 first write landed", 9'h040, 8'h01);
        read_chk("R8 busy write refused", 9'h050, 8'hFF);
        chk("R8 wel cleared by completion", wel, 0);
    endtask

    initial begin
        negs(5);
        rst = 1'b0;
        negs(2);
        t_reset();
        t_byte_write();
        t_no_wel();
        t_alias();
        t_wrap();
        t_full_wrap();
        t_off_boundary();
        t_opcode();
        t_protect();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule